// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small stored-program processor. A single 16-bit accumulator is the implicit target of every data operation, and each instruction names exactly one memory word. The datapath holds three registers: a program counter, the accumulator and an instruction register. Around them sit an arithmetic unit and the selectors that feed it. A hard-wired state machine sequences all of this. Instructions and data share one word-addressed memory, reached through a request / read-not-write interface. Reads return data combinationally in the same cycle.

Each instruction takes two cycles. First comes a fetch cycle, which reads the word at the program counter into the instruction register and advances the counter through the arithmetic unit. Then comes an execute cycle, which performs the operation encoded in the top four bits against the 12-bit address in the low bits.

The controller has three named states:

- `ST_FETCH` moves to `ST_EXEC` on every clock.
- `ST_EXEC` returns to `ST_FETCH`, except for the halt instruction, which moves to `ST_HALT`.
- `ST_HALT` stays in `ST_HALT` until reset.

An asynchronous active-low reset puts the machine in `ST_FETCH`.

Top module: `accum_core`

## Requirements
- R1: While reset is low and in the first cycle after its release, the core is in a fetch cycle with program counter zero: it requests a read of address 0, the halted output is low and the data drive-enable is low.
- R2: An instruction word carries its operation code in bits [15:12] and an operand address in bits [11:0]. Code 0 loads the addressed word into the accumulator. Code 2 adds it to the accumulator. Code 3 subtracts it from the accumulator. Each of these reads memory at the operand address in its execute cycle.
- R3: Every instruction starts with one fetch cycle that requests a read at the program counter. It is followed by exactly one execute cycle, and the program counter has advanced by one when that execute cycle begins.
- R4: Code 1 stores: in its execute cycle the core requests a write (read-not-write low) at the operand address, drives the accumulator on the data output and raises the drive-enable.
- R5: The drive-enable is high only in store execute cycles; in every other cycle it is low, and read-not-write is high whenever a request is made outside a store.
- R6: Code 4 loads the operand address into the program counter without any memory request in its execute cycle.
- R7: Code 5 jumps to the operand address only when accumulator bit 15 is clear; otherwise execution continues in sequence.
- R8: Code 6 jumps to the operand address only when the accumulator is nonzero.
- R9: Code 7 halts: from the following cycle the halted output is high and no memory request is made until the next reset.
- R10: Codes 8 to 15 make no memory request in their execute cycle and leave the accumulator unchanged; execution continues at the next address.
- R11: Addition and subtraction wrap modulo 2^16, and operand address 0xFFF is reachable as an ordinary data location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address of the current access |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 16 | Write data (accumulator value) |
| mem_wdata_oe | output | 1 | Drive-enable for the write data, high only during a store |
| mem_req | output | 1 | Memory access request |
| mem_rd_nwr | output | 1 | High for a read, low for a write |
| halted | output | 1 | High once the halt instruction has executed |

## Verification
The hardest condition to reach from the ports is a conditional branch that sees each polarity of the accumulator. That includes the negative-to-positive wrap at 0x8000 minus one and a result of exactly zero, followed by a not-taken branch. A dedicated program gets there by loading 0x8000, subtracting one, and then cancelling the result to zero, with a branch after each step. A second program sums an array through a loop that rewrites its own add instruction, so stores feed later fetches. A behavioural reference model steps alongside the core every cycle and checks address, request, direction, drive-enable, write data and halt.

// File: rtl/accum_core_pkg.sv
package accum_core_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } cpu_state_e;

    typedef enum logic [1:0] {
        FN_PASS_B = 2'd0,
        FN_ADD    = 2'd1,
        FN_SUB    = 2'd2,
        FN_INC_A  = 2'd3
    } alu_fn_e;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'd0;
    localparam logic [OP_W-1:0] OPC_STORE = 4'd1;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'd2;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'd3;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'd4;
    localparam logic [OP_W-1:0] OPC_JPOS  = 4'd5;
    localparam logic [OP_W-1:0] OPC_JNZ   = 4'd6;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'd7;

endpackage

// File: rtl/accum_core_alu.sv
module accum_core_alu
    import accum_core_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e        fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (fn)
            FN_PASS_B: y = b;
            FN_ADD:    y = a + b;
            FN_SUB:    y = a - b;
            FN_INC_A:  y = a + ONE;
            default:   y = b;
        endcase
    end

endmodule

// File: rtl/accum_core_ctrl.sv
module accum_core_ctrl
    import accum_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] ir_op,
    input  logic            acc_zero,
    input  logic            acc_neg,
    output cpu_state_e      state,
    output logic            ir_ld,
    output logic            pc_ld,
    output logic            acc_ld,
    output logic            addr_sel_ir,
    output logic            a_sel_pc,
    output logic            b_sel_ir,
    output alu_fn_e         alu_fn,
    output logic            req,
    output logic            rd_nwr,
    output logic            wr_oe
);

    cpu_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    assign state = state_q;

    // next state and control outputs
    always_comb begin
        state_d     = state_q;
        ir_ld       = 1'b0;
        pc_ld       = 1'b0;
        acc_ld      = 1'b0;
        addr_sel_ir = 1'b0;
        a_sel_pc    = 1'b0;
        b_sel_ir    = 1'b0;
        alu_fn      = FN_PASS_B;
        req         = 1'b0;
        rd_nwr      = 1'b1;
        wr_oe       = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                req      = 1'b1;
                ir_ld    = 1'b1;
                pc_ld    = 1'b1;
                a_sel_pc = 1'b1;
                alu_fn   = FN_INC_A;
                state_d  = ST_EXEC;
            end
            ST_EXEC: begin
                addr_sel_ir = 1'b1;
                state_d     = ST_FETCH;
                case (ir_op)
                    OPC_LOAD: begin
                        req    = 1'b1;
                        acc_ld = 1'b1;
                        alu_fn = FN_PASS_B;
                    end
                    OPC_STORE: begin
                        req    = 1'b1;
                        rd_nwr = 1'b0;
                        wr_oe  = 1'b1;
                    end
                    OPC_ADD: begin
                        req    = 1'b1;
                        acc_ld = 1'b1;
                        alu_fn = FN_ADD;
                    end
                    OPC_SUB: begin
                        req    = 1'b1;
                        acc_ld = 1'b1;
                        alu_fn = FN_SUB;
                    end
                    OPC_JUMP: begin
                        pc_ld    = 1'b1;
                        b_sel_ir = 1'b1;
                    end
                    OPC_JPOS: begin
                        pc_ld    = !acc_neg;
                        b_sel_ir = 1'b1;
                    end
                    OPC_JNZ: begin
                        pc_ld    = !acc_zero;
                        b_sel_ir = 1'b1;
                    end
                    OPC_HALT: state_d = ST_HALT;
                    default: ;
                endcase
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_FETCH;
        endcase
    end

    // R3: a fetch is always followed by an execute cycle
    a_r3_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_EXEC));

    // R9: once halted, the machine stays halted
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));

endmodule

// File: rtl/accum_core_dp.sv
module accum_core_dp
    import accum_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_ld,
    input  logic              pc_ld,
    input  logic              acc_ld,
    input  logic              addr_sel_ir,
    input  logic              a_sel_pc,
    input  logic              b_sel_ir,
    input  alu_fn_e           alu_fn,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic [OP_W-1:0]   ir_op,
    output logic              acc_zero,
    output logic              acc_neg
);

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] ir_q, acc_q, alu_a, alu_b, alu_y;
    logic [ADDR_W-1:0] pc_q, ir_addr;

    assign ir_addr = ir_q[ADDR_W-1:0];
    assign ir_op   = ir_q[DATA_W-1 -: OP_W];

    // address selector: program counter or operand field
    assign addr  = addr_sel_ir ? ir_addr : pc_q;
    // operand A selector: accumulator or program counter
    assign alu_a = a_sel_pc ? {{PAD_W{1'b0}}, pc_q} : acc_q;
    // operand B: memory data, or the operand field for jumps
    assign alu_b = b_sel_ir ? {{PAD_W{1'b0}}, ir_addr} : rdata;

    accum_core_alu #(.W(DATA_W)) u_alu (
        .fn (alu_fn),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            acc_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ir_ld)  ir_q  <= rdata;
            if (pc_ld)  pc_q  <= alu_y[ADDR_W-1:0];
            if (acc_ld) acc_q <= alu_y;
        end
    end

    assign acc      = acc_q;
    assign pc       = pc_q;
    assign acc_zero = (acc_q == '0);
    assign acc_neg  = acc_q[DATA_W-1];

    // R2: a loaded accumulator takes the value computed from memory data
    a_r2_acc_from_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ld && !a_sel_pc && !b_sel_ir) |=> (acc_q == $past(alu_y)));

endmodule

// File: rtl/accum_core.sv
module accum_core
    import accum_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = DATA_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic              mem_req,
    output logic              mem_rd_nwr,
    output logic              halted
);

    cpu_state_e        state;
    alu_fn_e           alu_fn;
    logic              ir_ld, pc_ld, acc_ld;
    logic              addr_sel_ir, a_sel_pc, b_sel_ir;
    logic              acc_zero, acc_neg;
    logic [OP_W-1:0]   ir_op;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc;

    accum_core_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ir_op       (ir_op),
        .acc_zero    (acc_zero),
        .acc_neg     (acc_neg),
        .state       (state),
        .ir_ld       (ir_ld),
        .pc_ld       (pc_ld),
        .acc_ld      (acc_ld),
        .addr_sel_ir (addr_sel_ir),
        .a_sel_pc    (a_sel_pc),
        .b_sel_ir    (b_sel_ir),
        .alu_fn      (alu_fn),
        .req         (mem_req),
        .rd_nwr      (mem_rd_nwr),
        .wr_oe       (mem_wdata_oe)
    );

    accum_core_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ir_ld       (ir_ld),
        .pc_ld       (pc_ld),
        .acc_ld      (acc_ld),
        .addr_sel_ir (addr_sel_ir),
        .a_sel_pc    (a_sel_pc),
        .b_sel_ir    (b_sel_ir),
        .alu_fn      (alu_fn),
        .rdata       (mem_rdata),
        .addr        (mem_addr),
        .acc         (acc),
        .pc          (pc),
        .ir_op       (ir_op),
        .acc_zero    (acc_zero),
        .acc_neg     (acc_neg)
    );

    assign mem_wdata = acc;
    assign halted    = (state == ST_HALT);

    // R5: the data drive-enable only accompanies a write request
    a_r5_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_oe |-> (mem_req && !mem_rd_nwr));

    // R9: no memory traffic while halted
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R3: a fetch advances the program counter by one
    a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));

    // R10: undefined codes leave the accumulator alone
    a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir_op[OP_W-1]) |=> $stable(acc));

endmodule

// File: tb/accum_core_test.sv
module accum_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_wdata_oe;
    logic        mem_req;
    logic        mem_rd_nwr;
    logic        halted;

    logic [15:0] mem     [4096];
    logic [15:0] ref_mem [4096];

    int vectors = 0;
    int fails   = 0;

    // reference model state: 0 fetch, 1 execute, 2 halted
    int          m_state;
    logic [11:0] m_pc;
    logic [15:0] m_acc;
    logic [15:0] m_ir;

    always #4 clk = ~clk;   // 125 MHz

    accum_core uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_req      (mem_req),
        .mem_rd_nwr   (mem_rd_nwr),
        .halted       (halted)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk)
        if (mem_req && !mem_rd_nwr) mem[mem_addr] <= mem_wdata;

    function automatic logic [15:0] ins(input int op, input int a);
        return {op[3:0], a[11:0]};
    endfunction

    function automatic string tag_of(input logic in_reset);
        logic [3:0] op;
        op = m_ir[15:12];
        if (in_reset)     return "R1";
        if (m_state == 0) return "R3";
        if (m_state == 2) return "R9";
        case (op)
            4'd0, 4'd2, 4'd3: return "R2";
            4'd1: return "R4";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) begin
            mem[i]     = 16'h0000;
            ref_mem[i] = 16'h0000;
        end
    endtask

    task automatic put(input int a, input logic [15:0] v);
        mem[a]     = v;
        ref_mem[a] = v;
    endtask

    // compare outputs against the model for the current cycle
    task automatic compare(input logic in_reset);
        logic        e_req, e_rnw, e_oe, e_halt;
        logic [11:0] e_addr;
        logic [3:0]  op;
        logic        bad;
        op     = m_ir[15:12];
        e_req  = 1'b0; e_rnw = 1'b1; e_oe = 1'b0; e_halt = 1'b0;
        e_addr = m_pc;
        if (m_state == 0) begin
            e_req = 1'b1;
        end else if (m_state == 1) begin
            e_addr = m_ir[11:0];
            if (op == 4'd0 || op == 4'd2 || op == 4'd3) e_req = 1'b1;
            if (op == 4'd1) begin e_req = 1'b1; e_rnw = 1'b0; e_oe = 1'b1; end
        end else begin
            e_halt = 1'b1;
        end
        bad = (mem_req !== e_req) || (halted !== e_halt) || (mem_wdata_oe !== e_oe);
        if (e_req && ((mem_rd_nwr !== e_rnw) || (mem_addr !== e_addr))) bad = 1'b1;
        if (e_oe && (mem_wdata !== m_acc)) bad = 1'b1;
        vectors++;
        if (bad) begin
            fails++;
            $display("FAIL %s t=%0t: req/rnw/oe/halt/addr/wdata = %b%b%b%b %h %h, expected %b%b%b%b %h %h",
                     tag_of(in_reset), $time, mem_req, mem_rd_nwr, mem_wdata_oe, halted,
                     mem_addr, mem_wdata, e_req, e_rnw, e_oe, e_halt, e_addr, m_acc);
        end
    endtask

    // advance the model across one rising edge
    task automatic advance();
        logic [3:0]  op;
        logic [11:0] a;
        op = m_ir[15:12];
        a  = m_ir[11:0];
        if (m_state == 0) begin
            m_ir    = ref_mem[m_pc];
            m_pc    = m_pc + 12'd1;
            m_state = 1;
        end else if (m_state == 1) begin
            m_state = 0;
            case (op)
                4'd0: m_acc = ref_mem[a];
                4'd1: ref_mem[a] = m_acc;
                4'd2: m_acc = m_acc + ref_mem[a];
                4'd3: m_acc = m_acc - ref_mem[a];
                4'd4: m_pc = a;
                4'd5: if (!m_acc[15]) m_pc = a;
                4'd6: if (m_acc != 16'h0) m_pc = a;
                4'd7: m_state = 2;
                default: ;
            endcase
        end
    endtask

    task automatic run_prog(input int limit);
        int halt_cycles;
        int cyc;
        rst_n = 1'b0;
        m_state = 0; m_pc = '0; m_acc = '0; m_ir = '0;
        halt_cycles = 0;
        cyc = 0;
        while (halt_cycles < 5) begin
            @(negedge clk);
            if (!rst_n) begin
                compare(1'b1);   // R1 reset state
                if (cyc >= 2) begin
                    rst_n = 1'b1;
                    advance();
                end
            end else begin
                compare(1'b0);
                advance();
                if (m_state == 2) halt_cycles++;
            end
            cyc++;
            if (cyc > limit) begin
                fails++;
                $display("FAIL R9 program did not halt within %0d cycles (state %0d, expected 2)", limit, m_state);
                break;
            end
        end
    endtask

    task automatic check_word(input string req, input int a, input logic [15:0] exp);
        vectors++;
        if (mem[a] !== exp) begin
            fails++;
            $display("FAIL %s mem[%h] = %h, expected %h", req, a[11:0], mem[a], exp);
        end
    endtask

    task automatic check_all(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== ref_mem[i]) bad++;
        vectors++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s %0d memory words differ from model, expected 0", req, bad);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stimulus
        // Program 1: sum five words at 0x020 via a self-rewriting add (R2, R4, R8, R11)
        clear_mem();
        put(12'h000, ins(0, 12'h030));
        put(12'h001, ins(2, 12'h020));
        put(12'h002, ins(1, 12'h030));
        put(12'h003, ins(0, 12'h001));
        put(12'h004, ins(2, 12'h031));
        put(12'h005, ins(1, 12'h001));
        put(12'h006, ins(0, 12'h032));
        put(12'h007, ins(3, 12'h031));
        put(12'h008, ins(1, 12'h032));
        put(12'h009, ins(6, 12'h000));
        put(12'h00A, ins(0, 12'h030));
        put(12'h00B, ins(1, 12'h033));
        put(12'h00C, ins(7, 0));
        put(12'h020, 16'h0003);
        put(12'h021, 16'h000A);
        put(12'h022, 16'h0100);
        put(12'h023, 16'h0007);
        put(12'h024, 16'hFFFF);
        put(12'h031, 16'h0001);
        put(12'h032, 16'h0005);
        run_prog(2000);
        check_word("R2", 12'h033, 16'h0113);
        check_word("R4", 12'h030, 16'h0113);
        check_word("R4", 12'h001, 16'h2025);
        check_word("R8", 12'h032, 16'h0000);
        check_all("R4");

        // Program 2: branch polarity, undefined code, jump, wrap, top address (R6-R11)
        clear_mem();
        put(12'h000, ins(0, 12'h020));
        put(12'h001, ins(5, 12'h005));
        put(12'h002, ins(3, 12'h021));
        put(12'h003, ins(5, 12'h006));
        put(12'h004, ins(7, 0));
        put(12'h005, ins(7, 0));
        put(12'h006, 16'hA123);
        put(12'h007, ins(4, 12'h009));
        put(12'h008, ins(7, 0));
        put(12'h009, ins(1, 12'h022));
        put(12'h00A, ins(3, 12'h023));
        put(12'h00B, ins(6, 12'h000));
        put(12'h00C, ins(2, 12'hFFF));
        put(12'h00D, ins(1, 12'hFFE));
        put(12'h00E, ins(7, 0));
        put(12'h020, 16'h8000);
        put(12'h021, 16'h0001);
        put(12'h023, 16'h7FFF);
        put(12'hFFF, 16'h0001);
        run_prog(2000);
        check_word("R11", 12'h022, 16'h7FFF);
        check_word("R11", 12'hFFE, 16'h0001);
        check_word("R10", 12'h123, 16'h0000);
        check_all("R7");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule